// File: doc/BRIEF.md
# Firmware Download Packet Receiver

This block is the receive side of a bootloader download protocol. A host pushes a stream of command bytes into it. Five commands drive the protocol: open a download session, close it, deliver a packet, load a read-back address, and fetch one byte. Each packet is a fixed 20-byte frame. The block checks the frame's additive checksum, its length and its word address. It copies the data bytes into an internal byte memory, one byte per cycle, and shows a busy code on a status pin while it does so. When the copy finishes, the pin shows the acknowledge code. A frame with a zero length closes the session.

The command input is a valid/ready byte stream. A byte moves only on a cycle where both `in_valid` and `in_ready` are high. The block holds `in_ready` low while it copies a frame into memory and while a read-back byte waits on the response port. The response port is also valid/ready. Once `rsp_valid` rises, it stays high and `rsp_data` stays fixed until the cycle the host takes the byte with `rsp_ready`. The status pin is plain and always shows the outcome of the most recent command that changes status.

The memory model keeps the low `2**MEM_AW` bytes of the byte address space. Byte address = 2 × word address + offset, and higher byte addresses alias onto these bytes. The word-address window check still uses the full 16-bit address.

Top module: `fw_dl_receiver`

## Requirements
- R1: After reset, `status` is 0x00 (idle), `in_ready` is 1, `rsp_valid` is 0, and every memory byte reads back as 0x00.
- R2: An input byte is consumed only when `in_valid` and `in_ready` are both high. `in_ready` is low while a frame is being copied or while `rsp_valid` is high. `rsp_valid` and `rsp_data` stay unchanged until `rsp_ready` is high.
- R3: Command codes and argument bytes:
  - 0x10 (open), 0x11 (close), 0x0C and 0x0B each take one argument byte, whose value does not matter.
  - 0x0E is followed by a 20-byte frame.
  - 0x12 is followed by two address bytes.
  - 0x13 takes no argument.
  - Any other code is a single byte with no effect on status or memory.
- R4: Frame byte layout:
  - byte 0: data length
  - byte 1: word address, low byte
  - byte 2: word address, high byte
  - bytes 3 to 18: data slots 0 to 15 (slots past the length are sent as zero)
  - byte 19: checksum
- R5: A frame is accepted only if byte 19 equals the modulo-256 sum of bytes 0 to 18. On a mismatch, `status` becomes 0xFF and no memory byte changes.
- R6: A length above 16 sets `status` to 0xFF and writes nothing, even when the checksum is correct.
- R7: A nonzero-length frame whose word address is below 0x1600 or above 0x2BBF sets `status` to 0xFF and writes nothing. Both 0x1600 and 0x2BBF are accepted.
- R8: For a valid frame of length L > 0:
  - `status` is 0x02 (busy) for exactly L cycles, starting in the cycle after the checksum byte is taken.
  - Data slot i is stored at byte address 2 × word address + i, reduced to its low `MEM_AW` bits.
  - After the L cycles, `status` becomes 0x01 (acknowledge).
- R9: The open command sets `status` to 0x01 and enables packets. A packet received while no session is open sets `status` to 0xFF and writes nothing.
- R10: A length-0 frame with a correct checksum, inside an open session, sets `status` to 0x01 without a busy phase. Its address is not checked, nothing is written, and the session closes.
- R11: The 0x12 command loads a word address, low byte first. Each 0x13 command then returns on the response port the byte at the current read byte address, starting at 2 × word address, and advances that address by one.
- R12: The close command sets `status` to 0x00 and ends the session. Codes 0x0C and 0x0B consume their argument byte and change neither status nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command stream byte valid |
| in_ready | output | 1 | Block can take a command stream byte |
| in_data | input | 8 | Command stream byte |
| rsp_valid | output | 1 | Read-back byte valid |
| rsp_ready | input | 1 | Host takes the read-back byte |
| rsp_data | output | 8 | Read-back byte |
| status | output | 8 | 0x00 idle, 0x01 acknowledge, 0x02 busy, 0xFF error |

## Verification
The bench aims at the edges of the address window: word addresses 0x1600 and 0x2BBF must be accepted, and 0x15FF and 0x2BC0 must be rejected. A design with an off-by-one compare would flip one of these outcomes. The rejected frame at 0x15FF aliases onto bytes that an earlier frame wrote, so a design that writes before it validates shows corrupted read-back. Other targets are:
- a length of 17 carrying a correct checksum;
- a single-bit checksum error;
- a packet sent before the session opens, and another sent after the zero-length terminator;
- the exact length of the busy phase;
- a read-back byte held under back-pressure.

A design that miscounts the busy phase, changes `rsp_data` while stalled, or accepts packets outside a session fails the matching check.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;
  localparam logic [7:0] CMD_OPEN   = 8'h10;
  localparam logic [7:0] CMD_CLOSE  = 8'h11;
  localparam logic [7:0] CMD_RDADDR = 8'h12;
  localparam logic [7:0] CMD_RDBYTE = 8'h13;
  localparam logic [7:0] CMD_PKT    = 8'h0E;
  localparam logic [7:0] CMD_JUMP   = 8'h0C;
  localparam logic [7:0] CMD_REBOOT = 8'h0B;

  localparam logic [7:0] ST_IDLE = 8'h00;
  localparam logic [7:0] ST_ACK  = 8'h01;
  localparam logic [7:0] ST_BUSY = 8'h02;
  localparam logic [7:0] ST_ERR  = 8'hFF;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ARG,
    PH_FRAME,
    PH_ADDR,
    PH_WRITE
  } phase_t;
endpackage

// File: rtl/fwdl_frame_rx.sv
module fwdl_frame_rx #(
  parameter int DATA_MAX = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  open_i,
  input  logic                  take_i,
  input  logic [7:0]            byte_i,
  output logic                  last_o,
  output logic                  sum_ok_o,
  output logic [7:0]            len_o,
  output logic [15:0]           addr_o,
  output logic [DATA_MAX*8-1:0] data_o
);
  localparam int FRAME_LEN = DATA_MAX + 4;
  localparam int IW        = $clog2(FRAME_LEN + 1);

  logic [IW-1:0] pos_q;
  logic [7:0]    sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      sum_q  <= '0;
      len_o  <= '0;
      addr_o <= '0;
    end else if (open_i) begin
      pos_q <= '0;
      sum_q <= '0;
    end else if (take_i) begin
      pos_q <= pos_q + 1'b1;
      sum_q <= sum_q + byte_i;
      if (pos_q == IW'(0)) len_o        <= byte_i;
      if (pos_q == IW'(1)) addr_o[7:0]  <= byte_i;
      if (pos_q == IW'(2)) addr_o[15:8] <= byte_i;
    end
  end

  for (genvar i = 0; i < DATA_MAX; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) data_o[i*8 +: 8] <= '0;
      else if (take_i && !open_i && pos_q == IW'(i + 3)) data_o[i*8 +: 8] <= byte_i;
    end
  end

  assign last_o   = take_i && (pos_q == IW'(FRAME_LEN - 1));
  assign sum_ok_o = (sum_q == byte_i);
endmodule

// File: rtl/fwdl_mem.sv
module fwdl_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else if (we_i) begin
      cell_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/fwdl_rdport.sv
module fwdl_rdport #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_i,
  input  logic [7:0]    mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [7:0]    rsp_data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raddr_o     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      if (load_i) raddr_o <= load_addr_i;
      if (step_i) begin
        rsp_data_o  <= mem_rdata_i;
        rsp_valid_o <= 1'b1;
        raddr_o     <= raddr_o + 1'b1;
      end else if (rsp_valid_o && rsp_ready_i) begin
        rsp_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fw_dl_receiver.sv
module fw_dl_receiver #(
  parameter int          DATA_MAX = 16,
  parameter int          MEM_AW   = 8,
  parameter logic [15:0] WIN_LO   = 16'h1600,
  parameter logic [15:0] WIN_HI   = 16'h2BBF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic [7:0] status
);
  import fwdl_pkg::*;

  localparam int WIW = $clog2(DATA_MAX + 1);

  phase_t      phase_q;
  logic [7:0]  cmd_q;
  logic        active_q;
  logic        addr_half_q;
  logic [7:0]  addr_lo_q;
  logic [WIW-1:0] wr_idx_q;

  logic        take;
  logic        f_open, f_take, f_last, f_sum_ok;
  logic [7:0]  f_len;
  logic [15:0] f_addr;
  logic [DATA_MAX*8-1:0] f_data;
  logic        len_bad, win_ok;

  logic              mem_we;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata, mem_rdata;
  logic              rd_load, rd_step;
  logic [MEM_AW-1:0] rd_load_addr;

  assign in_ready = (phase_q != PH_WRITE) && !rsp_valid;
  assign take     = in_valid && in_ready;

  assign f_open = take && (phase_q == PH_CMD) && (in_data == CMD_PKT);
  assign f_take = take && (phase_q == PH_FRAME);

  fwdl_frame_rx #(.DATA_MAX(DATA_MAX)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_i   (f_open),
    .take_i   (f_take),
    .byte_i   (in_data),
    .last_o   (f_last),
    .sum_ok_o (f_sum_ok),
    .len_o    (f_len),
    .addr_o   (f_addr),
    .data_o   (f_data)
  );

  assign len_bad = (f_len > 8'(DATA_MAX));
  assign win_ok  = (f_addr >= WIN_LO) && (f_addr <= WIN_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_CMD;
      cmd_q       <= '0;
      status      <= ST_IDLE;
      active_q    <= 1'b0;
      addr_half_q <= 1'b0;
      addr_lo_q   <= '0;
      wr_idx_q    <= '0;
    end else begin
      case (phase_q)
        PH_CMD: if (take) begin
          case (in_data)
            CMD_OPEN, CMD_CLOSE, CMD_JUMP, CMD_REBOOT: begin
              cmd_q   <= in_data;
              phase_q <= PH_ARG;
            end
            CMD_PKT:    phase_q <= PH_FRAME;
            CMD_RDADDR: begin
              phase_q     <= PH_ADDR;
              addr_half_q <= 1'b0;
            end
            default: ;
          endcase
        end
        PH_ARG: if (take) begin
          phase_q <= PH_CMD;
          if (cmd_q == CMD_OPEN) begin
            active_q <= 1'b1;
            status   <= ST_ACK;
          end else if (cmd_q == CMD_CLOSE) begin
            active_q <= 1'b0;
            status   <= ST_IDLE;
          end
        end
        PH_ADDR: if (take) begin
          if (!addr_half_q) begin
            addr_lo_q   <= in_data;
            addr_half_q <= 1'b1;
          end else begin
            phase_q <= PH_CMD;
          end
        end
        PH_FRAME: if (f_last) begin
          phase_q <= PH_CMD;
          if (!f_sum_ok || len_bad || !active_q) begin
            status <= ST_ERR;
          end else if (f_len == 8'd0) begin
            status   <= ST_ACK;
            active_q <= 1'b0;
          end else if (!win_ok) begin
            status <= ST_ERR;
          end else begin
            status   <= ST_BUSY;
            phase_q  <= PH_WRITE;
            wr_idx_q <= '0;
          end
        end
        PH_WRITE: begin
          wr_idx_q <= wr_idx_q + 1'b1;
          if (8'(wr_idx_q) == f_len - 8'd1) begin
            status  <= ST_ACK;
            phase_q <= PH_CMD;
          end
        end
        default: phase_q <= PH_CMD;
      endcase
    end
  end

  assign mem_we    = (phase_q == PH_WRITE);
  assign mem_waddr = MEM_AW'({f_addr, 1'b0} + 17'(wr_idx_q));
  assign mem_wdata = f_data[wr_idx_q*8 +: 8];

  fwdl_mem #(.AW(MEM_AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  assign rd_load      = take && (phase_q == PH_ADDR) && addr_half_q;
  assign rd_load_addr = MEM_AW'({in_data, addr_lo_q, 1'b0});
  assign rd_step      = take && (phase_q == PH_CMD) && (in_data == CMD_RDBYTE);

  fwdl_rdport #(.AW(MEM_AW)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (rd_load),
    .load_addr_i (rd_load_addr),
    .step_i      (rd_step),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (mem_raddr),
    .rsp_valid_o (rsp_valid),
    .rsp_ready_i (rsp_ready),
    .rsp_data_o  (rsp_data)
  );
endmodule

// File: rtl/fwdl_chk.sv
module fwdl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic [7:0] status
);
  // R8
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h02) |-> !in_ready);

  // R8
  busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h02) |=> (status == 8'h02 || status == 8'h01));

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R2
  rsp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !in_ready);

  // R5
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h00 || status == 8'h01 || status == 8'h02 || status == 8'hFF));
endmodule

bind fw_dl_receiver fwdl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .status    (status)
);

// File: tb/fw_dl_receiver_tb.sv
module fw_dl_receiver_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [256];

  always #4 clk = ~clk;

  fw_dl_receiver u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .status    (status)
  );

  // {word addr, length, data seed, corrupt checksum, expected status}
  localparam logic [40:0] VEC [7] = '{
    {16'h1600, 8'd16, 8'h30, 1'b0, 8'h01},
    {16'h2BBF, 8'd2,  8'hA1, 1'b0, 8'h01},
    {16'h15FF, 8'd4,  8'h55, 1'b0, 8'hFF},
    {16'h2BC0, 8'd4,  8'h66, 1'b0, 8'hFF},
    {16'h1610, 8'd17, 8'h77, 1'b0, 8'hFF},
    {16'h1620, 8'd5,  8'h88, 1'b1, 8'hFF},
    {16'h1630, 8'd1,  8'hC3, 1'b0, 8'h01}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [15:0] addr, input logic [7:0] len,
                            input logic [7:0] seed, input bit bad);
    logic [7:0] fr [20];
    logic [7:0] sum;
    fr[0] = len;
    fr[1] = addr[7:0];
    fr[2] = addr[15:8];
    for (int i = 0; i < 16; i++) fr[3+i] = (i < int'(len)) ? seed + 8'(i) : 8'h00;
    sum = 8'h00;
    for (int i = 0; i < 19; i++) sum = sum + fr[i];
    fr[19] = bad ? (sum ^ 8'h01) : sum;
    send_byte(8'h0E);
    for (int i = 0; i < 20; i++) send_byte(fr[i]);
  endtask

  task automatic set_addr(input logic [15:0] a);
    send_byte(8'h12);
    send_byte(a[7:0]);
    send_byte(a[15:8]);
  endtask

  task automatic read_byte(output logic [7:0] d);
    send_byte(8'h13);
    d = rsp_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, d0;
    int n;
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(status == 8'h00, "R1 status", status, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    set_addr(16'h1600);
    read_byte(d);
    chk(d == 8'h00, "R1 R11 cleared memory", d, 0);

    // R9 packet before open
    send_frame(16'h1600, 8'd2, 8'hEE, 1'b0);
    chk(status == 8'hFF, "R9 packet outside session", status, 8'hFF);
    set_addr(16'h1600);
    read_byte(d);
    chk(d == 8'h00, "R9 nothing written", d, 0);

    // R3 R12 jump and reboot codes consume one argument
    send_byte(8'h0C);
    send_byte(8'h10);
    chk(status == 8'hFF, "R12 jump no effect", status, 8'hFF);
    send_byte(8'h0B);
    send_byte(8'h11);
    chk(status == 8'hFF, "R3 R12 reboot argument consumed", status, 8'hFF);

    // R9 open session
    send_byte(8'h10);
    send_byte(8'h01);
    chk(status == 8'h01, "R9 open acknowledge", status, 1);

    // R4 R5 R6 R7 R8 R11 vector walk
    for (int v = 0; v < 7; v++) begin
      logic [15:0] a;
      logic [7:0]  len, seed, exp;
      bit bad;
      {a, len, seed, bad, exp} = VEC[v];
      send_frame(a, len, seed, bad);
      if (exp == 8'h01) begin
        n = 0;
        while (status == 8'h02) begin
          n++;
          @(negedge clk);
        end
        chk(n == int'(len), "R8 busy length", n, len);
        chk(status == 8'h01, "R8 acknowledge", status, 1);
        for (int i = 0; i < int'(len); i++)
          shadow[8'((a << 1) + 16'(i))] = seed + 8'(i);
      end else begin
        chk(status == 8'hFF, "R5 R6 R7 error status", status, exp);
      end
      set_addr(a);
      for (int i = 0; i < ((len > 16) ? 16 : int'(len)); i++) begin
        read_byte(d);
        chk(d == shadow[8'((a << 1) + 16'(i))], "R4 R11 read-back", d,
            shadow[8'((a << 1) + 16'(i))]);
      end
    end

    // R2 response back-pressure
    set_addr(16'h1600);
    rsp_ready = 1'b0;
    send_byte(8'h13);
    d0 = rsp_data;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b1, "R2 rsp held valid", rsp_valid, 1);
    chk(in_ready == 1'b0, "R2 input stalled", in_ready, 0);
    chk(rsp_data == d0 && d0 == shadow[8'h00], "R2 rsp data stable", rsp_data, shadow[8'h00]);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 rsp taken", rsp_valid, 0);

    // R3 unknown code ignored
    send_byte(8'h55);
    chk(status == 8'h01, "R3 unknown code", status, 1);
    read_byte(d);
    chk(d == shadow[8'h01], "R3 R11 pointer kept", d, shadow[8'h01]);

    // R10 terminator
    send_frame(16'h0000, 8'd0, 8'h00, 1'b0);
    chk(status == 8'h01, "R10 terminator acknowledge", status, 1);
    send_frame(16'h1700, 8'd2, 8'h12, 1'b0);
    chk(status == 8'hFF, "R9 R10 packet after terminator", status, 8'hFF);
    set_addr(16'h1700);
    read_byte(d);
    chk(d == shadow[8'h00], "R10 nothing written", d, shadow[8'h00]);

    // R12 close
    send_byte(8'h10);
    send_byte(8'h00);
    chk(status == 8'h01, "R9 reopen", status, 1);
    send_byte(8'h11);
    send_byte(8'h00);
    chk(status == 8'h00, "R12 close idle", status, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule